// File: doc/BRIEF.md
# I2C Test-Control and Interrupt-Status Register Unit

This unit is the register side of an I2C controller. It keeps two things: a system-test control word and a six-bit raw interrupt status word. Software reaches both, plus a per-bit interrupt enable mask, through a simple single-cycle write port and a combinational read port. The serial engine sits outside this unit. It reports its events as one-cycle strobes and takes back the test-mode selection and an SCL hold request.

The control word carries four fields. The first is a free-run bit, which picks what happens when a debug suspend arrives. The second is a system-test enable. The third is a two-bit test-mode field, which is locked to zero unless system test is enabled. The fourth is a set-all bit, which forces every status bit high. The status bits clear only when software writes ones to them. Interrupt, DMA and wakeup requests are formed from the status bits.

In stop mode, a suspend freezes the status bits. It also holds SCL low at the next bit boundary for a master, or at the next byte boundary for a slave. In free-run mode, a suspend lets the status bits keep updating but silences every request.

Top module: `i2c_testctl_unit`

## Requirements
- R1: After reset, every control field, the status bits and the enable mask read 0, and scl_hold, irq, dma_rx_req, dma_tx_req and wake_req are low.
- R2: The control word is at address 0, with the free-run bit at bit 0, the test enable at bit 1, the test mode at bits 3:2 and set-all at bit 4. The test mode reads 00 whenever the test enable is 0. A write whose bit 1 is 0 leaves the test mode at 00 whatever bits 3:2 hold. The free-run bit takes its written value whatever the test enable holds.
- R3: The test-mode output gives the stored mode. Code 2 raises scl_test_clk_en, code 3 raises loopback_en, and codes 0 (functional) and 1 (reserved) raise neither.
- R4: A control write with bit 4 set makes all six status bits (address 1) read 1 from the next cycle. They stay 1 for as long as set-all stays 1.
- R5: While set-all is 1, a write-one-to-clear to the status word has no effect. Writing set-all back to 0 clears no status bit.
- R6: A write to address 1 clears exactly the status bits written as 1 and leaves those written as 0.
- R7: A one-cycle pulse on evt[i] sets status bit i in the next cycle. The bit order from 0 is: NACK, ARDY, RRDY, XRDY, ROVR, XUDF. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: The enable mask is at address 2, bits 5:0. irq is the OR of the status bits ANDed with the mask. dma_rx_req follows the RRDY bit (bit 2), dma_tx_req follows the XRDY bit (bit 3), and wake_req is the OR of all status bits.
- R9: With free-run at 1 and suspend high, events still set status bits, but irq, dma_rx_req, dma_tx_req and wake_req are held low. The requests return once suspend falls.
- R10: With free-run at 0 and suspend high, scl_hold rises the cycle after a bit_done pulse when is_master is 1, or after a byte_done pulse when is_master is 0. scl_hold falls the cycle after suspend falls.
- R11: With free-run at 0 and suspend high, event pulses change no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 status, 2 mask) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| evt | input | 6 | One-cycle event strobes from the engine, one per status bit |
| is_master | input | 1 | Engine is acting as bus master |
| bit_done | input | 1 | Strobe at the end of each bit on the bus |
| byte_done | input | 1 | Strobe at the end of each byte on the bus |
| suspend | input | 1 | Debug suspend indication |
| scl_hold | output | 1 | Request to hold SCL low |
| tmode_out | output | 2 | Effective test-mode code |
| scl_test_clk_en | output | 1 | Continuous master SCL clock test selected |
| loopback_en | output | 1 | Loopback / pin-control test selected |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| wake_req | output | 1 | Wakeup request |

## Verification
The assertions assume four things about the inputs. The engine strobes (evt, bit_done, byte_done) are single-cycle pulses. Suspend and is_master change only between transfers of interest. Writes never arrive while reset is active. Under the stop-mode freeze property, software writes to the status word are still allowed, so that property only claims stability in cycles with no status write and no set-all forcing. The bench drives every input on the falling clock edge, pulses each strobe for exactly one cycle, and issues at most one register access per cycle. This keeps the stimulus inside those assumptions.

// File: rtl/i2c_tc_pkg.sv
package i2c_tc_pkg;
   localparam int NSTAT = 6;

   // status bit positions
   localparam int ST_NACK = 0;
   localparam int ST_ARDY = 1;
   localparam int ST_RRDY = 2;
   localparam int ST_XRDY = 3;
   localparam int ST_ROVR = 4;
   localparam int ST_XUDF = 5;

   // control word bit positions
   localparam int CB_FREE   = 0;
   localparam int CB_STEN   = 1;
   localparam int CB_MODE_L = 2;
   localparam int CB_MODE_H = 3;
   localparam int CB_SETALL = 4;
   localparam int CTRL_BITS = 5;

   // register addresses
   localparam int A_CTRL = 0;
   localparam int A_STAT = 1;
   localparam int A_MASK = 2;

   typedef enum logic [1:0] {
      TM_FUNC     = 2'd0,
      TM_RSVD     = 2'd1,
      TM_SCLTEST  = 2'd2,
      TM_LOOPBACK = 2'd3
   } tmode_e;

   typedef struct packed {
      logic   setall;
      tmode_e mode;
      logic   sten;
      logic   free;
   } ctrl_t;
endpackage

// File: rtl/i2c_tc_ctrl.sv
module i2c_tc_ctrl
   import i2c_tc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [DATA_W-1:0] wdata,
   output ctrl_t             ctrl_q,
   output logic              force_set,
   output logic              scl_test_clk_en,
   output logic              loopback_en
);
   ctrl_t ctrl_d;

   initial begin
      AST_CTRL_WIDTH: assert (DATA_W >= CTRL_BITS);
   end

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_ctrl) begin
         ctrl_d.free   = wdata[CB_FREE];
         ctrl_d.sten   = wdata[CB_STEN];
         ctrl_d.setall = wdata[CB_SETALL];
         if (wdata[CB_STEN])
            ctrl_d.mode = tmode_e'(wdata[CB_MODE_H:CB_MODE_L]);
         else
            ctrl_d.mode = TM_FUNC;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= ctrl_d;
   end

   assign force_set       = ctrl_q.setall | (wr_ctrl & wdata[CB_SETALL]);
   assign scl_test_clk_en = (ctrl_q.mode == TM_SCLTEST);
   assign loopback_en     = (ctrl_q.mode == TM_LOOPBACK);

   AST_TMODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.sten |-> ctrl_q.mode == TM_FUNC); // R2
   AST_FREE_ANY_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ctrl_q.free == $past(wdata[CB_FREE])); // R2
   AST_DECODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_test_clk_en && loopback_en)); // R3
endmodule

// File: rtl/i2c_tc_status.sv
module i2c_tc_status
   import i2c_tc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stat,
   input  logic              wr_mask,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NSTAT-1:0]  evt,
   input  logic              freeze,
   input  logic              force_set,
   output logic [NSTAT-1:0]  stat_q,
   output logic [NSTAT-1:0]  mask_q
);
   logic [NSTAT-1:0] evt_eff;
   logic [NSTAT-1:0] clr;

   initial begin
      AST_STAT_WIDTH: assert (DATA_W >= NSTAT);
   end

   assign evt_eff = evt & {NSTAT{~freeze}};
   assign clr     = wdata[NSTAT-1:0] & {NSTAT{wr_stat}};

   for (genvar i = 0; i < NSTAT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            stat_q[i] <= 1'b0;
         else if (force_set)    stat_q[i] <= 1'b1;
         else if (evt_eff[i])   stat_q[i] <= 1'b1;
         else if (clr[i])       stat_q[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] && !freeze |=> stat_q[i]); // R7
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= wdata[NSTAT-1:0];
   end

   AST_SETALL_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      force_set |=> &stat_q); // R4
   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat && !force_set |=>
         (stat_q & $past(wdata[NSTAT-1:0] & ~(evt & {NSTAT{~freeze}}))) == '0); // R6
   AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      freeze && !wr_stat && !force_set |=> $stable(stat_q)); // R11
endmodule

// File: rtl/i2c_tc_suspend.sv
module i2c_tc_suspend #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic suspend,
   input  logic free,
   input  logic is_master,
   input  logic bit_done,
   input  logic byte_done,
   output logic stop_req,
   output logic run_gate,
   output logic scl_hold
);
   logic susp_s;
   logic boundary;
   logic halt_q;

   initial begin
      AST_SYNC_RANGE: assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4);
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign susp_s = suspend;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 :0], suspend} ;
      end
      assign susp_s = chain[SYNC_STAGES-1];
   end

   assign stop_req = susp_s & ~free;
   assign run_gate = susp_s & free;
   assign boundary = is_master ? bit_done : byte_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    halt_q <= 1'b0;
      else if (!stop_req)            halt_q <= 1'b0;
      else if (boundary)             halt_q <= 1'b1;
   end

   assign scl_hold = halt_q;

   AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_req |=> !scl_hold); // R10
   AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req && boundary |=> scl_hold); // R10
   AST_HOLD_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_hold) |-> $past(stop_req)); // R10
endmodule

// File: rtl/i2c_testctl_unit.sv
module i2c_testctl_unit
   import i2c_tc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [5:0]        evt,
   input  logic              is_master,
   input  logic              bit_done,
   input  logic              byte_done,
   input  logic              suspend,
   output logic              scl_hold,
   output logic [1:0]        tmode_out,
   output logic              scl_test_clk_en,
   output logic              loopback_en,
   output logic              irq,
   output logic              dma_rx_req,
   output logic              dma_tx_req,
   output logic              wake_req
);
   localparam int CTRL_PAD = DATA_W - CTRL_BITS;
   localparam int STAT_PAD = DATA_W - NSTAT;

   ctrl_t            ctrl_q;
   logic             force_set;
   logic             wr_ctrl, wr_stat, wr_mask;
   logic [NSTAT-1:0] stat_q, mask_q;
   logic             stop_req, run_gate;

   initial begin
      AST_ADDR_WIDTH: assert (ADDR_W >= 2);
      AST_DATA_WIDTH: assert (DATA_W >= 8);
   end

   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
   assign wr_stat = wr_en && (wr_addr == ADDR_W'(A_STAT));
   assign wr_mask = wr_en && (wr_addr == ADDR_W'(A_MASK));

   i2c_tc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .wr_ctrl         (wr_ctrl),
      .wdata           (wr_data),
      .ctrl_q          (ctrl_q),
      .force_set       (force_set),
      .scl_test_clk_en (scl_test_clk_en),
      .loopback_en     (loopback_en)
   );

   i2c_tc_status #(.DATA_W(DATA_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stat   (wr_stat),
      .wr_mask   (wr_mask),
      .wdata     (wr_data),
      .evt       (evt),
      .freeze    (stop_req),
      .force_set (force_set),
      .stat_q    (stat_q),
      .mask_q    (mask_q)
   );

   i2c_tc_suspend #(.SYNC_STAGES(SYNC_STAGES)) u_susp (
      .clk       (clk),
      .rst_n     (rst_n),
      .suspend   (suspend),
      .free      (ctrl_q.free),
      .is_master (is_master),
      .bit_done  (bit_done),
      .byte_done (byte_done),
      .stop_req  (stop_req),
      .run_gate  (run_gate),
      .scl_hold  (scl_hold)
   );

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(A_CTRL): rd_data = {{CTRL_PAD{1'b0}}, ctrl_q};
         ADDR_W'(A_STAT): rd_data = {{STAT_PAD{1'b0}}, stat_q};
         ADDR_W'(A_MASK): rd_data = {{STAT_PAD{1'b0}}, mask_q};
         default:         rd_data = '0;
      endcase
   end

   assign tmode_out  = ctrl_q.mode;
   assign irq        = ~run_gate & (|(stat_q & mask_q));
   assign dma_rx_req = ~run_gate & stat_q[ST_RRDY];
   assign dma_tx_req = ~run_gate & stat_q[ST_XRDY];
   assign wake_req   = ~run_gate & (|stat_q);

   AST_FREE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      run_gate |-> !(irq || dma_rx_req || dma_tx_req || wake_req)); // R9
   AST_NO_HOLD_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q.free && $past(ctrl_q.free) |-> !scl_hold); // R10
   AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> wake_req); // R8
endmodule

// File: tb/i2c_testctl_unit_bench.sv
module i2c_testctl_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [5:0] evt = '0;
   logic       is_master = 1'b1;
   logic       bit_done = 1'b0;
   logic       byte_done = 1'b0;
   logic       suspend = 1'b0;
   logic       scl_hold;
   logic [1:0] tmode_out;
   logic       scl_test_clk_en, loopback_en;
   logic       irq, dma_rx_req, dma_tx_req, wake_req;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   i2c_testctl_unit u_i2c_testctl_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .evt(evt),
      .is_master(is_master), .bit_done(bit_done), .byte_done(byte_done),
      .suspend(suspend), .scl_hold(scl_hold), .tmode_out(tmode_out),
      .scl_test_clk_en(scl_test_clk_en), .loopback_en(loopback_en),
      .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
      .wake_req(wake_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulse_evt(input logic [5:0] e);
      @(negedge clk);
      evt = e;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic clear_all;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h3F);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(2'd0, d); check("R1 ctrl", d, 8'h00);
      rd(2'd1, d); check("R1 status", d, 8'h00);
      rd(2'd2, d); check("R1 mask", d, 8'h00);
      check("R1 outputs", {scl_hold, irq, dma_rx_req, dma_tx_req, wake_req}, 5'b0);
   endtask

   task automatic t_mode_lock;
      logic [7:0] d;
      wr(2'd0, 8'b0_10_0_1);               // R2: en=0, mode=2, free=1
      rd(2'd0, d); check("R2 mode locked, free set", d, 8'h01);
      check("R2 tmode_out zero", tmode_out, 2'd0);
      wr(2'd0, 8'b0_10_1_0);               // enable, mode 2
      check("R3 mode2 scl test", {tmode_out, scl_test_clk_en, loopback_en}, {2'd2, 2'b10});
      wr(2'd0, 8'b0_11_1_0);
      check("R3 mode3 loopback", {tmode_out, scl_test_clk_en, loopback_en}, {2'd3, 2'b01});
      wr(2'd0, 8'b0_01_1_0);
      check("R3 reserved code", {tmode_out, scl_test_clk_en, loopback_en}, {2'd1, 2'b00});
      wr(2'd0, 8'b0_11_0_0);               // disable: mode reads 0
      rd(2'd0, d); check("R2 disable clears mode", d, 8'h00);
      check("R3 functional outputs", {scl_test_clk_en, loopback_en}, 2'b00);
   endtask

   task automatic t_setall;
      logic [7:0] d;
      wr(2'd0, 8'h10);
      rd(2'd1, d); check("R4 set-all forces", d, 8'h3F);
      wr(2'd1, 8'h3F);
      rd(2'd1, d); check("R5 clear ignored while set-all", d, 8'h3F);
      wr(2'd0, 8'h00);
      rd(2'd1, d); check("R5 set-all release keeps bits", d, 8'h3F);
      wr(2'd1, 8'h05);
      rd(2'd1, d); check("R6 partial clear", d, 8'h3A);
      wr(2'd1, 8'h3A);
      rd(2'd1, d); check("R6 clear rest", d, 8'h00);
   endtask

   task automatic t_events;
      logic [7:0] d;
      pulse_evt(6'b100001);
      rd(2'd1, d); check("R7 NACK and XUDF set", d, 8'h21);
      // same-cycle clear and event on bit 0
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h21; evt = 6'b000001;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; evt = '0;
      rd(2'd1, d); check("R7 set wins over clear", d, 8'h01);
      wr(2'd1, 8'h01);
      pulse_evt(6'b001100);
      check("R8 irq masked off", irq, 1'b0);
      check("R8 dma and wake", {dma_rx_req, dma_tx_req, wake_req}, 3'b111);
      wr(2'd2, 8'h08);
      #1 check("R8 irq via mask", irq, 1'b1);
      wr(2'd1, 8'h08);
      #1 check("R8 irq after clear", {irq, dma_rx_req, dma_tx_req}, 3'b010);
      clear_all();
   endtask

   task automatic t_free_suspend;
      logic [7:0] d;
      wr(2'd0, 8'h01);
      wr(2'd2, 8'h3F);
      @(negedge clk) suspend = 1'b1;
      pulse_evt(6'b000100);
      rd(2'd1, d); check("R9 status updates in free", d, 8'h04);
      check("R9 requests gated", {irq, dma_rx_req, dma_tx_req, wake_req}, 4'b0);
      @(negedge clk) bit_done = 1'b1;
      @(negedge clk) bit_done = 1'b0;
      check("R10 no hold in free", scl_hold, 1'b0);
      suspend = 1'b0;
      #1 check("R9 requests return", {irq, dma_rx_req, wake_req}, 3'b111);
      clear_all();
   endtask

   task automatic t_stop_suspend;
      logic [7:0] d;
      is_master = 1'b1;
      @(negedge clk) suspend = 1'b1;
      pulse_evt(6'b111111);
      rd(2'd1, d); check("R11 events ignored in stop", d, 8'h00);
      check("R10 no hold before boundary", scl_hold, 1'b0);
      @(negedge clk) bit_done = 1'b1;
      @(negedge clk) bit_done = 1'b0;
      check("R10 master hold after bit", scl_hold, 1'b1);
      suspend = 1'b0;
      @(negedge clk);
      check("R10 release", scl_hold, 1'b0);
      is_master = 1'b0;
      suspend = 1'b1;
      @(negedge clk) bit_done = 1'b1;
      @(negedge clk) bit_done = 1'b0;
      check("R10 slave ignores bit end", scl_hold, 1'b0);
      byte_done = 1'b1;
      @(negedge clk) byte_done = 1'b0;
      check("R10 slave hold after byte", scl_hold, 1'b1);
      suspend = 1'b0;
      @(negedge clk);
      check("R10 slave release", scl_hold, 1'b0);
      pulse_evt(6'b000010);
      rd(2'd1, d); check("R11 updates resume", d, 8'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode_lock();
      t_setall();
      t_events();
      t_free_suspend();
      t_stop_suspend();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule